// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO Engine

This block keeps up to 64 independent word-wide FIFOs inside a single on-chip memory of 128 pages, each page 16 words of 32 bits. Every queue is described by one 32-bit setup word. The word places the queue on a page boundary, picks a power-of-two length and sets two 3-bit watermark codes. A producer pushes one word into a queue by naming the queue index. A consumer pops one word the same way and receives it one cycle later.

For each queue the engine holds a read offset, a write offset and an occupancy count. From these it derives four status bits per queue: empty, nearly empty, nearly full and full. An interrupt controller next to the block uses these bits. The block does not place regions, does not check them for overlap and does not raise interrupts.

Top module: `mq_fifo_engine`

## Requirements
- R1: Setup word layout: bits 21:14 hold the base page number, bits 25:24 a length code (0,1,2,3 give 16,32,64,128 words), bits 28:26 the nearly-empty code and bits 31:29 the nearly-full code. Entry storage address is base*16 plus the queue offset. Entries leave a queue in the order they entered, and queues on distinct pages never see each other's data.
- R2: A queue whose setup word is zero, or whose base page is one of pages 0..3 (reserved), is inactive. Pushes to it are ignored and pops from it return 0.
- R3: A pop from a queue that holds no entries returns 0.
- R4: A push to a full active queue is discarded and leaves the stored entries intact. `ovf_pulse` goes high for exactly the cycle after that push is sampled, and only for such a push.
- R5: Writing a setup word to a queue empties it: its count and both offsets return to zero, and the entries it held are lost. Writing zero releases the queue.
- R6: Read and write offsets wrap modulo the queue length, so a queue keeps FIFO order across any number of fill and drain rounds.
- R7: The empty bit is set when the count is 0 and the full bit when the count equals the length. After reset all queues show empty=1, nearly-empty=1, nearly-full=0, full=0. Status bits reflect the count one clock edge after the count changes.
- R8: With code w, the threshold is 0 for w=0 and 2^(w-1) otherwise. The nearly-empty bit is set when count <= the nearly-empty threshold.
- R9: The nearly-full bit is set when (length - count) <= the nearly-full threshold.
- R10: `get_rvld` is asserted in the cycle after `get_vld` is sampled, for every pop request, and `get_rdata` carries that pop's result in that cycle.
- R11: A push and a pop to the same queue in one cycle are both served against the state before that cycle. The count is then unchanged, a pop of an empty queue still returns 0 while the push lands, and a push to a full queue is still discarded.
- R12: A push or pop naming the queue that receives a setup write in the same cycle is ignored; the pop returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_qid | input | 6 | Queue receiving the setup word |
| cfg_wdata | input | 32 | Setup word |
| put_vld | input | 1 | Push request |
| put_qid | input | 6 | Queue to push into |
| put_data | input | 32 | Word to push |
| get_vld | input | 1 | Pop request |
| get_qid | input | 6 | Queue to pop from |
| get_rvld | output | 1 | Pop result valid, one cycle after request |
| get_rdata | output | 32 | Popped word, 0 when nothing was popped |
| ovf_pulse | output | 1 | Push to a full queue was discarded |
| q_empty | output | 64 | Per-queue empty bit |
| q_nempty | output | 64 | Per-queue nearly-empty bit |
| q_nfull | output | 64 | Per-queue nearly-full bit |
| q_full | output | 64 | Per-queue full bit |

## Verification
The bench fills a 16-word queue to the last slot and then pushes once more. A design with an off-by-one full test would accept that word and return a 17th entry, or raise the overflow one entry early. Queues on neighbouring pages are filled in interleaved order, and a 16-word queue is filled and drained across its wrap point several times. Wrong page scaling or a missing offset mask would then return another queue's words or stale data. The watermark bits are checked at every count of a 128-word queue, which catches a threshold decoded one power of two off or compared with < instead of <=. Same-cycle push/pop, pops of empty, released, reserved-page and just-rewritten queues, and setup writes that collide with traffic expose designs that serve a stale count or return leftover memory contents instead of 0.

// File: rtl/mqf_pkg.sv
package mqf_pkg;

  localparam int CNT_W = 8;  // holds 0..128 entries
  localparam int OFF_W = 7;  // offset inside the largest queue

  typedef struct packed {
    logic [2:0]  nf_code;    // 31:29
    logic [2:0]  ne_code;    // 28:26
    logic [1:0]  size_code;  // 25:24
    logic [1:0]  spare;      // 23:22
    logic [7:0]  base_page;  // 21:14
    logic [13:0] low;        // 13:0
  } qcfg_t;

  function automatic logic [CNT_W-1:0] size_words(input logic [1:0] code);
    return CNT_W'(8'd16 << code);
  endfunction

  function automatic logic [CNT_W-1:0] wm_thresh(input logic [2:0] code);
    return (code == 3'd0) ? '0 : CNT_W'(8'd1 << (code - 3'd1));
  endfunction

endpackage

// File: rtl/mqf_sram.sv
module mqf_sram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/mqf_flag_unit.sv
module mqf_flag_unit
  import mqf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       size_code,
  input  logic [2:0]       ne_code,
  input  logic [2:0]       nf_code,
  input  logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             nempty,
  output logic             nfull,
  output logic             full
);

  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] room;

  assign cap  = size_words(size_code);
  assign room = cap - cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty  <= 1'b1;
      nempty <= 1'b1;
      nfull  <= 1'b0;
      full   <= 1'b0;
    end else begin
      empty  <= (cnt == '0);
      nempty <= (cnt <= wm_thresh(ne_code));
      nfull  <= (room <= wm_thresh(nf_code));
      full   <= (cnt == cap);
    end
  end

  // R7: the count handed in by the pointer logic never exceeds the length
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= cap);

endmodule

// File: rtl/mq_fifo_engine.sv
module mq_fifo_engine
  import mqf_pkg::*;
#(
  parameter int NUM_Q      = 64,
  parameter int DATA_W     = 32,
  parameter int NUM_PAGES  = 128,
  parameter int PAGE_WORDS = 16,
  parameter int RSVD_PAGES = 4,
  localparam int QID_W  = $clog2(NUM_Q),
  localparam int ADDR_W = $clog2(NUM_PAGES * PAGE_WORDS),
  localparam int PG_SH  = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [QID_W-1:0]  cfg_qid,
  input  logic [31:0]       cfg_wdata,
  input  logic              put_vld,
  input  logic [QID_W-1:0]  put_qid,
  input  logic [DATA_W-1:0] put_data,
  input  logic              get_vld,
  input  logic [QID_W-1:0]  get_qid,
  output logic              get_rvld,
  output logic [DATA_W-1:0] get_rdata,
  output logic              ovf_pulse,
  output logic [NUM_Q-1:0]  q_empty,
  output logic [NUM_Q-1:0]  q_nempty,
  output logic [NUM_Q-1:0]  q_nfull,
  output logic [NUM_Q-1:0]  q_full
);

  function automatic logic q_live(input qcfg_t c);
    return (c != '0) && (int'(c.base_page) >= RSVD_PAGES) &&
           (int'(c.base_page) < NUM_PAGES);
  endfunction

  qcfg_t            cfg_q  [NUM_Q];
  logic [OFF_W-1:0] head_q [NUM_Q];
  logic [OFF_W-1:0] tail_q [NUM_Q];
  logic [CNT_W-1:0] cnt_q  [NUM_Q];

  // push side
  qcfg_t            pc;
  logic [CNT_W-1:0] p_cnt;
  logic [OFF_W-1:0] p_tail, p_mask, tail_nx;
  logic             p_full, p_clash, put_ok, put_ovf;
  logic [ADDR_W-1:0] waddr;

  assign pc      = cfg_q[put_qid];
  assign p_cnt   = cnt_q[put_qid];
  assign p_tail  = tail_q[put_qid];
  assign p_mask  = OFF_W'(size_words(pc.size_code) - 8'd1);
  assign tail_nx = (p_tail + 7'd1) & p_mask;
  assign p_full  = (p_cnt == size_words(pc.size_code));
  assign p_clash = cfg_we && (cfg_qid == put_qid);
  assign put_ok  = put_vld && q_live(pc) && !p_full && !p_clash;
  assign put_ovf = put_vld && q_live(pc) && p_full && !p_clash;
  assign waddr   = ADDR_W'((32'(pc.base_page) << PG_SH) + 32'(p_tail));

  // pop side
  qcfg_t            gc;
  logic [CNT_W-1:0] g_cnt;
  logic [OFF_W-1:0] g_head, g_mask, head_nx;
  logic             g_clash, get_ok, same_q;
  logic [ADDR_W-1:0] raddr;

  assign gc      = cfg_q[get_qid];
  assign g_cnt   = cnt_q[get_qid];
  assign g_head  = head_q[get_qid];
  assign g_mask  = OFF_W'(size_words(gc.size_code) - 8'd1);
  assign head_nx = (g_head + 7'd1) & g_mask;
  assign g_clash = cfg_we && (cfg_qid == get_qid);
  assign get_ok  = get_vld && q_live(gc) && (g_cnt != '0) && !g_clash;
  assign raddr   = ADDR_W'((32'(gc.base_page) << PG_SH) + 32'(g_head));
  assign same_q  = (put_qid == get_qid);

  logic              hit_q;
  logic [DATA_W-1:0] ram_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_Q; i++) begin
        cfg_q[i]  <= '0;
        head_q[i] <= '0;
        tail_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
      get_rvld  <= 1'b0;
      hit_q     <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      get_rvld  <= get_vld;
      hit_q     <= get_ok;
      ovf_pulse <= put_ovf;
      if (put_ok) tail_q[put_qid] <= tail_nx;
      if (get_ok) head_q[get_qid] <= head_nx;
      if (put_ok && !(get_ok && same_q)) cnt_q[put_qid] <= p_cnt + 8'd1;
      if (get_ok && !(put_ok && same_q)) cnt_q[get_qid] <= g_cnt - 8'd1;
      if (cfg_we) begin
        cfg_q[cfg_qid]  <= qcfg_t'(cfg_wdata);
        head_q[cfg_qid] <= '0;
        tail_q[cfg_qid] <= '0;
        cnt_q[cfg_qid]  <= '0;
      end
    end
  end

  mqf_sram #(.DATA_W(DATA_W), .DEPTH(NUM_PAGES * PAGE_WORDS)) u_sram (
    .clk   (clk),
    .we    (put_ok),
    .waddr (waddr),
    .wdata (put_data),
    .re    (get_ok),
    .raddr (raddr),
    .rdata (ram_rd)
  );

  assign get_rdata = hit_q ? ram_rd : '0;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_flags
    mqf_flag_unit u_flag (
      .clk       (clk),
      .rst       (rst),
      .size_code (cfg_q[g].size_code),
      .ne_code   (cfg_q[g].ne_code),
      .nf_code   (cfg_q[g].nf_code),
      .cnt       (cnt_q[g]),
      .empty     (q_empty[g]),
      .nempty    (q_nempty[g]),
      .nfull     (q_nfull[g]),
      .full      (q_full[g])
    );
  end

  a_r4_ovf_needs_put: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> $past(put_vld));

  a_r10_rvld_tracks_get: assert property (@(posedge clk) disable iff (rst)
    get_rvld == $past(get_vld));

  a_r3_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
    (get_rvld && $past(g_cnt == '0)) |-> (get_rdata == '0));

  a_r6_tail_in_range: assert property (@(posedge clk) disable iff (rst)
    p_tail <= p_mask);

endmodule

// File: tb/sim_mq_fifo_engine.sv
module sim_mq_fifo_engine;

  localparam int NQ = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [5:0]  cfg_qid;
  logic [31:0] cfg_wdata;
  logic        put_vld;
  logic [5:0]  put_qid;
  logic [31:0] put_data;
  logic        get_vld;
  logic [5:0]  get_qid;
  logic        get_rvld;
  logic [31:0] get_rdata;
  logic        ovf_pulse;
  logic [NQ-1:0] q_empty, q_nempty, q_nfull, q_full;

  always #10 clk = ~clk;

  mq_fifo_engine u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_wdata(cfg_wdata),
    .put_vld(put_vld), .put_qid(put_qid), .put_data(put_data),
    .get_vld(get_vld), .get_qid(get_qid), .get_rvld(get_rvld), .get_rdata(get_rdata),
    .ovf_pulse(ovf_pulse), .q_empty(q_empty), .q_nempty(q_nempty),
    .q_nfull(q_nfull), .q_full(q_full)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q [$];
  logic [31:0] mdl [NQ][$];
  logic [31:0] mcfg [NQ];
  logic [31:0] seq = 32'h1000;

  function automatic logic [31:0] mk(int base, int len, int ne, int nf);
    return {3'(nf), 3'(ne), 2'(len), 2'b00, 8'(base), 14'd0};
  endfunction
  function automatic int cap_of(logic [31:0] w);
    return 16 << w[25:24];
  endfunction
  function automatic int thr_of(logic [2:0] c);
    return (c == 0) ? 0 : (1 << (c - 1));
  endfunction
  function automatic bit live_of(logic [31:0] w);
    return (w != 0) && (w[21:14] >= 4) && (w[21:14] < 128);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops the expected pop result
  always @(negedge clk) begin
    if (!rst && !done && get_rvld) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected pop result: actual %0h expected none", get_rdata);
      end else begin
        chk("R1/R3/R10 pop data", {32'd0, get_rdata}, {32'd0, exp_q.pop_front()});
      end
    end
  end

  // one cycle of traffic, called at a falling edge
  task automatic op(bit pv, int pq, logic [31:0] pd, bit gv, int gq,
                    bit cw = 0, int cq = 0, logic [31:0] cd = 0);
    bit p_ok, p_ovf, p_live;
    put_vld = pv; put_qid = 6'(pq); put_data = pd;
    get_vld = gv; get_qid = 6'(gq);
    cfg_we = cw; cfg_qid = 6'(cq); cfg_wdata = cd;
    p_live = pv && live_of(mcfg[pq]) && !(cw && cq == pq);
    p_ovf  = p_live && (mdl[pq].size() >= cap_of(mcfg[pq]));
    p_ok   = p_live && !p_ovf;
    if (gv) begin
      if (live_of(mcfg[gq]) && !(cw && cq == gq) && mdl[gq].size() > 0)
        exp_q.push_back(mdl[gq].pop_front());
      else
        exp_q.push_back(32'd0);
    end
    if (p_ok) mdl[pq].push_back(pd);
    if (cw) begin
      mcfg[cq] = cd;
      mdl[cq].delete();
    end
    @(negedge clk);
    if (pv) chk("R4 overflow strobe", {63'd0, ovf_pulse}, {63'd0, p_ovf});
    put_vld = 0; get_vld = 0; cfg_we = 0;
  endtask

  task automatic push(int q);
    seq = seq + 32'h11;
    op(1, q, seq, 0, 0);
  endtask
  task automatic pop(int q);
    op(0, 0, 0, 1, q);
  endtask
  task automatic setq(int q, logic [31:0] w);
    op(0, 0, 0, 0, 0, 1, q, w);
  endtask

  // status bits against the model (R7 R8 R9), one edge after the count moved
  task automatic chkflags(int q);
    int n, cap;
    @(negedge clk);
    n   = mdl[q].size();
    cap = cap_of(mcfg[q]);
    chk("R7 empty", {63'd0, q_empty[q]}, {63'd0, n == 0});
    chk("R7 full", {63'd0, q_full[q]}, {63'd0, n == cap});
    chk("R8 nearly empty", {63'd0, q_nempty[q]}, {63'd0, n <= thr_of(mcfg[q][28:26])});
    chk("R9 nearly full", {63'd0, q_nfull[q]}, {63'd0, (cap - n) <= thr_of(mcfg[q][31:29])});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) mcfg[i] = 0;
    rst = 1; cfg_we = 0; cfg_qid = 0; cfg_wdata = 0;
    put_vld = 0; put_qid = 0; put_data = 0; get_vld = 0; get_qid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R7 reset state
    chk("R7 reset empty", {0, q_empty}, {0, {NQ{1'b1}}});
    chk("R7 reset nearly empty", {0, q_nempty}, {0, {NQ{1'b1}}});
    chk("R7 reset nearly full", {0, q_nfull}, 64'd0);
    chk("R7 reset full", {0, q_full}, 64'd0);
    chk("R10 reset rvld", {63'd0, get_rvld}, 64'd0);
    chk("R4 reset ovf", {63'd0, ovf_pulse}, 64'd0);

    // R1 R8 R9 R7 R4: 16-word queue, ne code 2 (thr 2), nf code 1 (thr 1)
    setq(3, mk(4, 0, 2, 1));
    chkflags(3);
    for (int i = 0; i < 17; i++) begin
      push(3);
      chkflags(3);
    end
    for (int i = 0; i < 17; i++) begin
      pop(3);                         // last one is R3: empty returns 0
      chkflags(3);
    end

    // R6: wrap the 16-word queue several times
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 11; i++) push(3);
      chkflags(3);
      for (int i = 0; i < 11; i++) pop(3);
    end
    chkflags(3);

    // R1: neighbouring pages, interleaved traffic
    setq(7, mk(5, 1, 0, 0));
    setq(20, mk(8, 3, 0, 7));
    for (int i = 0; i < 10; i++) begin
      push(3); push(7);
    end
    for (int i = 0; i < 10; i++) begin
      pop(7); pop(3);
    end

    // R8 R9 R7 R4 on the 128-word queue, nf code 7 (thr 64)
    for (int i = 0; i < 129; i++) begin
      push(20);
      chkflags(20);
    end
    for (int i = 0; i < 128; i++) pop(20);
    chkflags(20);

    // R11: same-cycle push and pop on one queue
    op(1, 3, 32'hAAAA0001, 1, 3);    // empty: pop returns 0, push lands
    chkflags(3);
    push(3);
    for (int i = 0; i < 5; i++) op(1, 3, 32'hBBBB0000 + i, 1, 3);
    chkflags(3);
    pop(3); pop(3);
    chkflags(3);

    // R2: unconfigured and reserved-page queues
    push(10);
    chkflags(10);
    pop(10);
    setq(11, mk(2, 0, 0, 0));
    push(11);
    chkflags(11);
    pop(11);

    // R5: rewriting a setup word empties the queue; zero releases it
    push(7); push(7); push(7);
    chkflags(7);
    setq(7, mk(5, 1, 0, 0));
    chkflags(7);
    pop(7);
    push(7); push(7);
    setq(7, 32'd0);
    chkflags(7);
    pop(7);
    push(7);                          // R2: released queue ignores pushes
    chkflags(7);

    // R12: traffic colliding with a setup write to the same queue
    op(1, 3, 32'hCCCC0001, 0, 0, 1, 3, mk(4, 0, 2, 1));
    chkflags(3);
    pop(3);
    push(3);
    op(0, 0, 0, 1, 3, 1, 3, mk(4, 0, 2, 1));
    chkflags(3);
    pop(3);

    repeat (3) @(negedge clk);
    chk("R10 all pops answered", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule